// File: doc/BRIEF.md
# Dual 8-bit Direction-Programmable I/O Port

This block provides two 8-bit general-purpose ports, A and B, on a small internal register bus. Each port has a data latch and a direction register. Every pin has three signals: an output value, an output enable and an input sample. Each pin is set to drive or to listen one bit at a time.

Software writes the direction register to choose which bits drive. It writes the data register to set the levels those bits drive. Reading the data register returns a mix: bits that drive return the latched value, and bits that listen return the pin. Each pin input passes through a single capture flop before it reaches the read path.

Reset returns every pin to listening. Reset does not touch the data latches, so they keep any value written before it. Accesses to addresses that do not decode leave all state alone and return zero.

Top module: `gpio_pair`

## Requirements
- R1: Each bit of `a_oe`/`b_oe` equals the matching bit of that port's direction register; 1 means the pin drives and 0 means it listens.
- R2: A write to a port's data register loads its latch for every bit, whatever the direction. The latch appears on `a_out`/`b_out` from the clock edge that takes the write.
- R3: A read of a port's data register returns, bit by bit, the latch where the direction bit is 1. Where the direction bit is 0, it returns the pin level present before the previous clock edge.
- R4: While `rst_n` is low, both direction registers are 0, so `a_oe` and `b_oe` are 0.
- R5: Reset does not alter the data latches: a value written before reset is still on `a_out`/`b_out` after it.
- R6: Decode on the 13-bit address: port A data at 0x0000, port B data at 0x0001, port A direction at 0x0004, port B direction at 0x0005. All 13 bits take part, so no alias exists.
- R7: A read of a direction register returns the last value written to it.
- R8: An access to any other address changes no register, holds `bus_hit` low and returns 0 on `bus_rdata`.
- R9: `bus_rdata` is 0 whenever `bus_rd` is low. `bus_hit` is high only during a read or write to one of the four decoded addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 13 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during `bus_rd` |
| bus_hit | output | 1 | Access targets a port register |
| a_in | input | 8 | Port A pin levels |
| a_out | output | 8 | Port A output latch |
| a_oe | output | 8 | Port A per-bit drive enable |
| b_in | input | 8 | Port B pin levels |
| b_out | output | 8 | Port B output latch |
| b_oe | output | 8 | Port B per-bit drive enable |

## Verification
Each kind of internal fault shows at the ports within a cycle or two.

- A direction bit holding the wrong value shows on the enable outputs at once. It also flips that bit of the data read, which returns the pin where it should return the latch, or the reverse.
- A latch that missed a write is visible on the output bus in the cycle after the write, even while its bit is an input.
- A decode fault shows as a register that changes after a stray write, or as a nonzero read or raised hit at a foreign address.

The bench sweeps direction, latch and pin patterns on both ports so that every bit is seen in both modes.

// File: rtl/gpio_pair.sv
module gpio_pair #(
  parameter int ADDR_W = 13,
  parameter int W = 8,
  parameter logic [ADDR_W-1:0] A_DATA_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] B_DATA_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] A_DIR_ADDR  = 'h4,
  parameter logic [ADDR_W-1:0] B_DIR_ADDR  = 'h5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              bus_hit,
  input  logic [W-1:0]      a_in,
  output logic [W-1:0]      a_out,
  output logic [W-1:0]      a_oe,
  input  logic [W-1:0]      b_in,
  output logic [W-1:0]      b_out,
  output logic [W-1:0]      b_oe
);

  logic [W-1:0] a_lat, b_lat, a_dir, b_dir, a_smp, b_smp;
  logic sel_ad, sel_bd, sel_ar, sel_br;

  assign sel_ad = bus_addr == A_DATA_ADDR;
  assign sel_bd = bus_addr == B_DATA_ADDR;
  assign sel_ar = bus_addr == A_DIR_ADDR;
  assign sel_br = bus_addr == B_DIR_ADDR;

  assign bus_hit = (bus_wr | bus_rd) & (sel_ad | sel_bd | sel_ar | sel_br);

  always_ff @(posedge clk) begin
    if (bus_wr && sel_ad) a_lat <= bus_wdata;
    if (bus_wr && sel_bd) b_lat <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_dir <= '0;
      b_dir <= '0;
    end else begin
      if (bus_wr && sel_ar) a_dir <= bus_wdata;
      if (bus_wr && sel_br) b_dir <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    a_smp <= a_in;
    b_smp <= b_in;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_ad) bus_rdata = (a_lat & a_dir) | (a_smp & ~a_dir);
      if (sel_bd) bus_rdata = (b_lat & b_dir) | (b_smp & ~b_dir);
      if (sel_ar) bus_rdata = a_dir;
      if (sel_br) bus_rdata = b_dir;
    end
  end

  assign a_out = a_lat;
  assign b_out = b_lat;
  assign a_oe  = a_dir;
  assign b_oe  = b_dir;

endmodule

module gpio_pair_chk #(
  parameter int ADDR_W = 13,
  parameter int W = 8,
  parameter logic [ADDR_W-1:0] A_DATA_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] B_DATA_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] A_DIR_ADDR  = 'h4,
  parameter logic [ADDR_W-1:0] B_DIR_ADDR  = 'h5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic              bus_hit,
  input logic [W-1:0]      a_in,
  input logic [W-1:0]      a_out,
  input logic [W-1:0]      a_oe,
  input logic [W-1:0]      b_in,
  input logic [W-1:0]      b_out,
  input logic [W-1:0]      b_oe
);

  logic known;
  assign known = bus_addr == A_DATA_ADDR || bus_addr == B_DATA_ADDR ||
                 bus_addr == A_DIR_ADDR  || bus_addr == B_DIR_ADDR;

  a_r4_reset_dir: assert property (@(posedge clk)
    $rose(rst_n) |-> (a_oe == '0 && b_oe == '0));

  a_r2_latch_a: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA_ADDR) |=> a_out == $past(bus_wdata));

  a_r2_latch_b: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == B_DATA_ADDR) |=> b_out == $past(bus_wdata));

  a_r1_dir_a: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR_ADDR) |=> a_oe == $past(bus_wdata));

  a_r1_dir_b: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == B_DIR_ADDR) |=> b_oe == $past(bus_wdata));

  a_r3_read_a: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DATA_ADDR) |->
      (((bus_rdata ^ a_out) & a_oe) == '0 &&
       ((bus_rdata ^ $past(a_in)) & ~a_oe) == '0));

  a_r8_miss_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !known) |-> (bus_rdata == '0 && !bus_hit));

  a_r8_miss_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && known) |=> ($stable(a_oe) && $stable(b_oe)));

  a_r9_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);

endmodule

bind gpio_pair gpio_pair_chk #(
  .ADDR_W(ADDR_W), .W(W),
  .A_DATA_ADDR(A_DATA_ADDR), .B_DATA_ADDR(B_DATA_ADDR),
  .A_DIR_ADDR(A_DIR_ADDR), .B_DIR_ADDR(B_DIR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_hit(bus_hit), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/tb_gpio_pair.sv
module tb_gpio_pair;
  logic clk = 0, rst_n = 0;
  logic [12:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0, a_in = '0, b_in = '0;
  logic [7:0] bus_rdata, a_out, a_oe, b_out, b_oe;
  logic bus_hit;
  int runs = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_pair dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [12:0] a, output logic [7:0] d, output logic h);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata; h = bus_hit;
    @(negedge clk); bus_rd = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic h;
    repeat (3) @(negedge clk);
    chk("R4 a_oe in reset", a_oe, 8'h00);
    chk("R4 b_oe in reset", b_oe, 8'h00);
    chk("R9 rdata idle", bus_rdata, 8'h00);
    rst_n = 1;
    // R2: latch loads while all bits are inputs
    wr(13'h0000, 8'h5A); chk("R2 a_out input mode", a_out, 8'h5A);
    wr(13'h0001, 8'hC3); chk("R2 b_out input mode", b_out, 8'hC3);
    chk("R1 a_oe still zero", a_oe, 8'h00);
    // R3/R1/R7 sweep: direction x latch x pin patterns
    for (int di = 0; di < 256; di += 17) begin
      wr(13'h0004, di[7:0]); wr(13'h0005, ~di[7:0]);
      chk("R1 a_oe", a_oe, di[7:0]);
      chk("R1 b_oe", b_oe, ~di[7:0]);
      rd(13'h0004, d, h); chk("R7 a dir read", d, di[7:0]);
      rd(13'h0005, d, h); chk("R7 b dir read", d, ~di[7:0]);
      for (int k = 0; k < 4; k++) begin
        logic [7:0] la, lb, pa, pb;
        la = 8'h96 ^ (8'h3B * k[7:0]); lb = ~la ^ di[7:0];
        pa = 8'h0F << k; pb = 8'hA5 ^ (8'h11 * k[7:0]);
        wr(13'h0000, la); wr(13'h0001, lb);
        @(negedge clk); a_in = pa; b_in = pb;
        chk("R2 a_out", a_out, la);
        rd(13'h0000, d, h);
        chk("R3 a read", d, (la & di[7:0]) | (pa & ~di[7:0]));
        chk("R9 hit on data read", {7'd0, h}, 8'd1);
        rd(13'h0001, d, h);
        chk("R3 b read", d, (lb & ~di[7:0]) | (pb & di[7:0]));
      end
    end
    // R8: foreign addresses, including high-bit aliases (R6)
    wr(13'h0004, 8'h3C); wr(13'h0005, 8'hE1);
    wr(13'h0000, 8'h77); wr(13'h0001, 8'h88);
    for (int a = 0; a < 24; a++) begin
      logic [12:0] ad;
      ad = (a < 16) ? a[12:0] : (13'h1000 | a[12:0]) - 13'd16;
      if (ad == 0 || ad == 1 || ad == 4 || ad == 5) continue;
      wr(ad, 8'hFF);
      rd(ad, d, h);
      chk("R8 miss rdata", d, 8'h00);
      chk("R8 miss hit", {7'd0, h}, 8'd0);
    end
    chk("R8 a_oe kept", a_oe, 8'h3C);
    chk("R8 b_oe kept", b_oe, 8'hE1);
    chk("R8 a_out kept", a_out, 8'h77);
    chk("R6 b_out kept", b_out, 8'h88);
    rd(13'h0004, d, h); chk("R6 a dir at 0x0004", d, 8'h3C);
    chk("R9 hit on dir read", {7'd0, h}, 8'd1);
    // R9: no access means no hit
    @(negedge clk); bus_addr = 13'h0000; #1;
    chk("R9 idle hit", {7'd0, bus_hit}, 8'd0);
    // R5/R4: reset clears directions, keeps latches
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R4 a_oe cleared", a_oe, 8'h00);
    chk("R4 b_oe cleared", b_oe, 8'h00);
    chk("R5 a_out kept", a_out, 8'h77);
    chk("R5 b_out kept", b_out, 8'h88);
    rst_n = 1;
    @(negedge clk); a_in = 8'h12;
    rd(13'h0000, d, h); chk("R3 all input after reset", d, 8'h12);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule